// File: doc/BRIEF.md
# Nested Indirect Buffer Call Controller

This block decides where a command processor takes its next command word from. There are three possible sources: the main command ring, a first-level indirect buffer and a second-level indirect buffer. It gives the word fetcher a fetch address, a source tag and a valid flag. Addresses count in command words. The ring pointer wraps inside a fixed window of `RING_WORDS` words that starts at `RING_BASE`.

The packet decoder starts a buffer by writing two registers. The buffer start address is written first, or in the same cycle. The write of the buffer length is the trigger. That write acts as a call: the calling source keeps its own position, and fetching moves to the new buffer from the next cycle. Each word that the fetcher consumes advances the active position by one. Inside a buffer, each consumed word also uses up one unit of the remaining length. When the remaining length reaches zero, the controller returns to the caller. Each return takes one cycle in which no word is offered. The controller tracks at most two buffer levels below the ring. A call made from the second level is dropped and raises a sticky error.

Top module: `ib_call_ctrl`

## Requirements
- R1: After reset the source tag is 0 (ring), the fetch address is `RING_BASE`, `fetch_valid` is 1 and `nest_err` is 0.
- R2: While on the ring, each `fetch_adv` raises the fetch address by one word in the next cycle. After the word at `RING_BASE+RING_WORDS-1` the address wraps to `RING_BASE`.
- R3: A length write from the ring moves the source tag to 1 (first level) and the fetch address to the latched buffer address in the next cycle. A write of the address register alone changes neither output.
- R4: Inside a buffer of length N>0, each `fetch_adv` raises the fetch address by one word. After the N-th advance, `fetch_valid` is 0 in the next cycle.
- R5: A length write from the first level moves the source tag to 2. When the second-level buffer is used up, the source tag returns to 1 at the first-level word that follows the launching word.
- R6: When the first-level buffer is used up, the source returns to the ring at the word after the last ring word consumed. The ring position does not move while a buffer is active.
- R7: A length write while the source tag is 2 is ignored: the tag, the address and the remaining length are unchanged. It sets `nest_err`, which stays at 1 until reset.
- R8: A zero-length buffer causes a single cycle with `fetch_valid` at 0 under the new tag. The caller then resumes at its unchanged address, and no word is fetched from the empty buffer.
- R9: Returns unwind one level per cycle, each with `fetch_valid` at 0. When the last word of the first level is consumed in the same cycle that launches the second level, the end of the second level takes two idle cycles before the ring resumes.
- R10: When the address write and the length write arrive in the same cycle, the new buffer starts at the address presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_adv | input | 1 | Fetcher consumed the word at `fetch_addr` |
| ib_addr_wr | input | 1 | Write strobe for the buffer start address register |
| ib_addr_val | input | AW | Buffer start address (word address) |
| ib_size_wr | input | 1 | Write strobe for the buffer length; starts the call |
| ib_size_val | input | LW | Buffer length in words |
| fetch_addr | output | AW | Word address of the next command word |
| fetch_src | output | 2 | Source tag: 0 ring, 1 first level, 2 second level |
| fetch_valid | output | 1 | The word at `fetch_addr` may be fetched this cycle |
| nest_err | output | 1 | Sticky: a call was attempted from the second level |

## Verification
The assertions assume that the fetcher pulses `fetch_adv`, and the decoder pulses `ib_size_wr`, only in cycles where `fetch_valid` is 1. The return cycles are idle by design, and a launch word cannot be decoded in a cycle where nothing was offered. The directed tasks advance and call only after sampling `fetch_valid` high. Each return cycle is driven as an idle tick, so the stimulus stays inside that contract even in the cascaded-return and zero-length cases.

// File: rtl/ibc_pkg.sv
// Shared types for the indirect buffer call controller.
// Assumes: exactly two buffer levels below the ring; tag values are fixed.
package ibc_pkg;
    localparam int IB_LEVELS = 2;

    typedef enum logic [1:0] {
        SRC_RING = 2'd0,
        SRC_L1   = 2'd1,
        SRC_L2   = 2'd2
    } src_e;
endpackage

// File: rtl/ibc_ring_ptr.sv
// Ring read position: a word index that wraps inside a window of
// RING_WORDS words starting at RING_BASE.
// Assumes: step is asserted only while the ring is the active source.
module ibc_ring_ptr #(
    parameter int AW = 32,
    parameter int RING_WORDS = 1024,
    parameter logic [AW-1:0] RING_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam int RIW = (RING_WORDS > 1) ? $clog2(RING_WORDS) : 1;
    localparam logic [RIW-1:0] LAST = RIW'(RING_WORDS - 1);

    logic [RIW-1:0] idx_q;

    // Advance the ring index on each consumed word, wrapping at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)           idx_q <= '0;
        else if (step)        idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    // Map the index into the ring window.
    always_comb addr = RING_BASE + AW'(idx_q);

    assert_ring_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && idx_q == LAST) |=> (addr == RING_BASE));
endmodule

// File: rtl/ibc_level_ctx.sv
// Context of one indirect buffer level: the current word address and the
// remaining length. Load starts the buffer; step consumes one word.
// Assumes: load and step never coincide, and step only when not empty.
module ibc_level_ctx #(
    parameter int AW = 32,
    parameter int LW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          empty
);
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;

    // Hold the buffer position and count down the words still to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_len;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    // Present the position and the exhaustion flag.
    always_comb begin
        addr  = addr_q;
        empty = (rem_q == '0);
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty);
    assert_load_step_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));
endmodule

// File: rtl/ibc_depth_ctrl.sv
// Nesting control: tracks the active level (0 ring, 1, 2) and turns length
// writes into calls and exhausted buffers into one-level returns.
// Assumes: fetch_adv and size_wr are asserted only while fetch_valid is 1.
module ibc_depth_ctrl
    import ibc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_adv,
    input  logic                 size_wr,
    input  logic [IB_LEVELS-1:0] lvl_empty,
    output src_e                 cur_src,
    output logic                 fetch_valid,
    output logic                 step_ring,
    output logic [IB_LEVELS-1:0] lvl_load,
    output logic [IB_LEVELS-1:0] lvl_step,
    output logic                 nest_err
);
    localparam logic [1:0] TOP_LVL = 2'(IB_LEVELS);

    logic [1:0] lvl_q;
    logic       err_q;
    logic       cur_empty;
    logic       do_call;
    logic       do_ovf;
    logic       adv_ok;

    // Decide whether the active buffer is used up and classify the requests.
    always_comb begin
        cur_empty = 1'b0;
        for (int i = 0; i < IB_LEVELS; i++) begin
            if (lvl_q == 2'(i + 1)) cur_empty = lvl_empty[i];
        end
        fetch_valid = !cur_empty;
        do_call     = size_wr && fetch_valid && (lvl_q != TOP_LVL);
        do_ovf      = size_wr && fetch_valid && (lvl_q == TOP_LVL);
        adv_ok      = fetch_adv && fetch_valid;
        step_ring   = adv_ok && (lvl_q == 2'd0);
        cur_src     = src_e'(lvl_q);
        nest_err    = err_q;
    end

    // Per-level load on a call from the level below, step while active.
    for (genvar g = 0; g < IB_LEVELS; g++) begin : g_lvl
        localparam logic [1:0] CALLER = 2'(g);
        localparam logic [1:0] SELF   = 2'(g + 1);
        assign lvl_load[g] = do_call && (lvl_q == CALLER);
        assign lvl_step[g] = adv_ok && (lvl_q == SELF);
    end

    // Move the active level: pop on exhaustion, push on an accepted call.
    always_ff @(posedge clk) begin
        if (!rst_n)            lvl_q <= 2'd0;
        else if (!fetch_valid) lvl_q <= lvl_q - 2'd1;
        else if (do_call)      lvl_q <= lvl_q + 2'd1;
    end

    // Record a call attempted beyond the deepest level; kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (do_ovf) err_q <= 1'b1;
    end

    assert_depth_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= TOP_LVL);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nest_err |=> nest_err);
    assert_overflow_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && fetch_valid && cur_src == SRC_L2) |=> (nest_err && cur_src == SRC_L2));
    assert_call_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && fetch_valid && cur_src != SRC_L2) |=> (lvl_q == $past(lvl_q) + 2'd1));
    assert_return_one_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (lvl_q == $past(lvl_q) - 2'd1));
endmodule

// File: rtl/ib_call_ctrl.sv
// Top of the nested indirect buffer call controller. Latches the buffer
// address register, owns the ring pointer and one context per buffer level,
// and selects the fetch address by the active source.
// Assumes: the decoder writes the address before or with the length, and
// requests arrive only while fetch_valid is 1.
module ib_call_ctrl
    import ibc_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 20,
    parameter int RING_WORDS = 1024,
    parameter logic [AW-1:0] RING_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_adv,
    input  logic          ib_addr_wr,
    input  logic [AW-1:0] ib_addr_val,
    input  logic          ib_size_wr,
    input  logic [LW-1:0] ib_size_val,
    output logic [AW-1:0] fetch_addr,
    output logic [1:0]    fetch_src,
    output logic          fetch_valid,
    output logic          nest_err
);
    logic [AW-1:0]        ib_addr_q;
    logic [AW-1:0]        call_addr;
    logic [AW-1:0]        ring_addr;
    logic                 step_ring;
    logic [IB_LEVELS-1:0] lvl_load;
    logic [IB_LEVELS-1:0] lvl_step;
    logic [IB_LEVELS-1:0] lvl_empty;
    logic [AW-1:0]        lvl_addr [IB_LEVELS];
    src_e                 cur_src;

    // Latch the buffer start address written by the decoder.
    always_ff @(posedge clk) begin
        if (!rst_n)          ib_addr_q <= '0;
        else if (ib_addr_wr) ib_addr_q <= ib_addr_val;
    end

    // A same-cycle address write takes effect for the call it accompanies.
    always_comb call_addr = ib_addr_wr ? ib_addr_val : ib_addr_q;

    ibc_depth_ctrl u_depth (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_adv   (fetch_adv),
        .size_wr     (ib_size_wr),
        .lvl_empty   (lvl_empty),
        .cur_src     (cur_src),
        .fetch_valid (fetch_valid),
        .step_ring   (step_ring),
        .lvl_load    (lvl_load),
        .lvl_step    (lvl_step),
        .nest_err    (nest_err)
    );

    ibc_ring_ptr #(
        .AW         (AW),
        .RING_WORDS (RING_WORDS),
        .RING_BASE  (RING_BASE)
    ) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_ring),
        .addr  (ring_addr)
    );

    for (genvar g = 0; g < IB_LEVELS; g++) begin : g_ctx
        ibc_level_ctx #(
            .AW (AW),
            .LW (LW)
        ) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (lvl_load[g]),
            .load_addr (call_addr),
            .load_len  (ib_size_val),
            .step      (lvl_step[g]),
            .addr      (lvl_addr[g]),
            .empty     (lvl_empty[g])
        );
    end

    // Select the fetch address of the active source.
    always_comb begin
        fetch_src  = cur_src;
        fetch_addr = ring_addr;
        for (int i = 0; i < IB_LEVELS; i++) begin
            if (cur_src == src_e'(i + 1)) fetch_addr = lvl_addr[i];
        end
    end

    assert_ring_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != SRC_RING) |=> $stable(ring_addr));
    assert_adv_when_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_adv |-> fetch_valid);
    assert_call_when_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ib_size_wr |-> fetch_valid);
    assert_call_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_size_wr && ib_addr_wr && cur_src == SRC_RING) |=> (fetch_addr == $past(ib_addr_val)));
endmodule

// File: tb/ib_call_ctrl_tb.sv
module ib_call_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RB = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_adv = 1'b0;
    logic        ib_addr_wr = 1'b0;
    logic [31:0] ib_addr_val = '0;
    logic        ib_size_wr = 1'b0;
    logic [15:0] ib_size_val = '0;
    logic [31:0] fetch_addr;
    logic [1:0]  fetch_src;
    logic        fetch_valid;
    logic        nest_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    ib_call_ctrl #(
        .AW (32), .LW (16), .RING_WORDS (16), .RING_BASE (RB)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .fetch_adv (fetch_adv),
        .ib_addr_wr (ib_addr_wr), .ib_addr_val (ib_addr_val),
        .ib_size_wr (ib_size_wr), .ib_size_val (ib_size_val),
        .fetch_addr (fetch_addr), .fetch_src (fetch_src),
        .fetch_valid (fetch_valid), .nest_err (nest_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs away from the edge, clear them after it.
    task automatic cyc(input logic adv, input logic aw, input logic [31:0] av,
                       input logic sw, input logic [15:0] sv);
        fetch_adv = adv; ib_addr_wr = aw; ib_addr_val = av;
        ib_size_wr = sw; ib_size_val = sv;
        @(posedge clk); #1;
        fetch_adv = 1'b0; ib_addr_wr = 1'b0; ib_size_wr = 1'b0;
    endtask

    task automatic idle();        cyc(1'b0, 1'b0, '0, 1'b0, '0); endtask
    task automatic adv(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(); idle(); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 src", 32'(fetch_src), 32'd0);
        chk("R1 addr", fetch_addr, RB);
        chk("R1 valid", 32'(fetch_valid), 32'd1);
        chk("R1 err", 32'(nest_err), 32'd0);
    endtask

    task automatic t_ring_wrap();
        do_reset();
        adv(15);
        chk("R2 last word", fetch_addr, RB + 32'd15);
        adv(1);
        chk("R2 wrap", fetch_addr, RB);
    endtask

    task automatic t_call_l1();
        do_reset();
        adv(3);
        cyc(1'b0, 1'b1, 32'h8000, 1'b0, '0);
        chk("R3 addr write only src", 32'(fetch_src), 32'd0);
        chk("R3 addr write only addr", fetch_addr, RB + 32'd3);
        cyc(1'b1, 1'b0, '0, 1'b1, 16'd4);
        chk("R3 src", 32'(fetch_src), 32'd1);
        chk("R3 addr", fetch_addr, 32'h8000);
        adv(3);
        chk("R4 addr", fetch_addr, 32'h8003);
        chk("R4 valid", 32'(fetch_valid), 32'd1);
        adv(1);
        chk("R4 exhausted", 32'(fetch_valid), 32'd0);
        idle();
        chk("R6 src", 32'(fetch_src), 32'd0);
        chk("R6 addr", fetch_addr, RB + 32'd4);
        chk("R6 valid", 32'(fetch_valid), 32'd1);
    endtask

    task automatic t_nested();
        do_reset();
        cyc(1'b1, 1'b1, 32'h8000, 1'b1, 16'd5);
        chk("R10 same-cycle addr", fetch_addr, 32'h8000);
        adv(2);
        cyc(1'b0, 1'b1, 32'h9000, 1'b0, '0);
        cyc(1'b1, 1'b0, '0, 1'b1, 16'd2);
        chk("R5 src l2", 32'(fetch_src), 32'd2);
        chk("R5 addr l2", fetch_addr, 32'h9000);
        adv(2);
        chk("R5 l2 exhausted", 32'(fetch_valid), 32'd0);
        idle();
        chk("R5 back src", 32'(fetch_src), 32'd1);
        chk("R5 back addr", fetch_addr, 32'h8003);
        adv(2);
        chk("R6 l1 exhausted", 32'(fetch_valid), 32'd0);
        idle();
        chk("R6 ring resume", fetch_addr, RB + 32'd1);
        chk("R6 ring src", 32'(fetch_src), 32'd0);
    endtask

    task automatic t_overflow();
        do_reset();
        cyc(1'b0, 1'b1, 32'h8000, 1'b1, 16'd4);
        cyc(1'b0, 1'b1, 32'h9000, 1'b1, 16'd3);
        adv(1);
        cyc(1'b0, 1'b1, 32'hA000, 1'b1, 16'd7);
        chk("R7 src kept", 32'(fetch_src), 32'd2);
        chk("R7 addr kept", fetch_addr, 32'h9001);
        chk("R7 err set", 32'(nest_err), 32'd1);
        adv(2);
        chk("R7 length kept", 32'(fetch_valid), 32'd0);
        idle();
        chk("R7 back l1", fetch_addr, 32'h8000);
        adv(4);
        idle();
        chk("R7 ring", fetch_addr, RB);
        chk("R7 err sticky", 32'(nest_err), 32'd1);
    endtask

    task automatic t_zero();
        do_reset();
        adv(2);
        cyc(1'b0, 1'b1, 32'h8000, 1'b1, 16'd0);
        chk("R8 idle valid", 32'(fetch_valid), 32'd0);
        chk("R8 idle src", 32'(fetch_src), 32'd1);
        idle();
        chk("R8 resume src", 32'(fetch_src), 32'd0);
        chk("R8 resume addr", fetch_addr, RB + 32'd2);
        chk("R8 resume valid", 32'(fetch_valid), 32'd1);
    endtask

    task automatic t_cascade();
        do_reset();
        cyc(1'b0, 1'b1, 32'h8000, 1'b1, 16'd2);
        adv(1);
        cyc(1'b1, 1'b1, 32'h9000, 1'b1, 16'd1);
        chk("R9 l2 src", 32'(fetch_src), 32'd2);
        chk("R9 l2 valid", 32'(fetch_valid), 32'd1);
        adv(1);
        chk("R9 pop l2 idle", 32'(fetch_valid), 32'd0);
        idle();
        chk("R9 l1 idle src", 32'(fetch_src), 32'd1);
        chk("R9 l1 idle valid", 32'(fetch_valid), 32'd0);
        idle();
        chk("R9 ring src", 32'(fetch_src), 32'd0);
        chk("R9 ring addr", fetch_addr, RB);
        chk("R9 ring valid", 32'(fetch_valid), 32'd1);
    endtask

    initial begin
        #1;
        t_reset();
        t_ring_wrap();
        t_call_l1();
        t_nested();
        t_overflow();
        t_zero();
        t_cascade();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule